// File: doc/BRIEF.md
# Stack Window Guard

This block checks the effective address of each load and store in a 32-bit processor against a programmable stack window. Two limit registers bound the window: a low limit and a high limit. Software reads and writes them through the special-register move operations. The check applies only to accesses that use the stack-pointer register (register 1) as an address operand. An access outside the window raises a hardware exception request. With the request come a cause code and the faulting address.

The pipeline presents each memory access with:
- an access-valid strobe;
- the computed effective address;
- the base and index register numbers;
- a flag that tells the register-plus-register form from the register-plus-immediate form.

The exception outputs are registered, so they appear on the cycle after the access. Address generation and exception vectoring belong to the surrounding pipeline.

Top module: `stack_window_guard`

## Requirements
- R1: After reset the low limit reads 0 and the high limit reads 0xFFFFFFFF. No address then raises an exception, and `exc_req` is 0.
- R2: A write with `sr_wr_en` high and `sr_wr_sel` = 0x800 loads the low limit. A write with `sr_wr_sel` = 0x802 loads the high limit. `sr_rd_data` shows the current value of the limit that `sr_rd_sel` picks, and 0 for any other selector. A write to any other selector changes neither limit.
- R3: A checked access is a violation when its address is below the low limit or above the high limit. Both comparisons are unsigned 32-bit. An address equal to either limit is not a violation.
- R4: An access is checked when its base register number is 1. In the register-plus-register form (`acc_rr` = 1) it is also checked when its index register number is 1.
- R5: In the register-plus-immediate form (`acc_rr` = 0), only the base register number decides whether the access is checked. `acc_idx` has no effect.
- R6: An access that does not use register 1 as a checked operand never raises an exception, whatever its address.
- R7: `exc_req` is high for exactly the one cycle after each violating access that has `acc_vld` high. It stays low when `acc_vld` is low.
- R8: While `exc_req` is high, `exc_cause` is 7 and `exc_addr` holds the faulting address. While `exc_req` is low, both are 0.
- R9: A limit write affects accesses from the next cycle on. An access in the same cycle as the write is checked against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | A load or store is presented this cycle |
| acc_addr | input | 32 | Effective address of the access |
| acc_base | input | 5 | Base register number |
| acc_idx | input | 5 | Index register number (used only in register-plus-register form) |
| acc_rr | input | 1 | 1 = register-plus-register form, 0 = register-plus-immediate form |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_wr_sel | input | 14 | Special-register number for the write |
| sr_wr_data | input | 32 | Write data |
| sr_rd_sel | input | 14 | Special-register number for the read |
| sr_rd_data | output | 32 | Read data (0 when no limit is selected) |
| exc_req | output | 1 | Hardware exception request, one cycle per violation |
| exc_cause | output | 5 | Exception cause code, 7 on a violation |
| exc_addr | output | 32 | Faulting effective address |

## Verification
Assertions check several rules on every cycle:
- an exception follows only a valid access;
- the cause code and captured address match that access;
- an in-window access, or one that does not use register 1, stays quiet;
- the limits reset to the open window and load what is written.

Some behaviours can only be shown by the bench's scenarios. These are the exact boundary addresses on both limits, the index operand being honoured in one address form and ignored in the other, and a write landing in the same cycle as an access. Back-to-back violations, and the selector decoding of reads and writes, also need these scenarios.

// File: rtl/stack_window_guard_pkg.sv
`timescale 1ns/1ps
package stack_window_guard_pkg;
   // Addressing forms of a load/store
   typedef enum logic {
      FORM_REG_IMM = 1'b0,
      FORM_REG_REG = 1'b1
   } addr_form_e;

   // Index of each limit register inside the limit bank
   localparam int unsigned LIM_LO = 0;
   localparam int unsigned LIM_HI = 1;
   localparam int unsigned LIM_N  = 2;
endpackage

// File: rtl/stack_window_guard_limits.sv
`timescale 1ns/1ps
module stack_window_guard_limits
   import stack_window_guard_pkg::*;
#(
   parameter int unsigned          AW     = 32,
   parameter int unsigned          SRW    = 14,
   parameter logic [SRW-1:0]       LO_SEL = 'h800,
   parameter logic [SRW-1:0]       HI_SEL = 'h802
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [SRW-1:0] wr_sel,
   input  logic [AW-1:0]  wr_data,
   input  logic [SRW-1:0] rd_sel,
   output logic [AW-1:0]  rd_data,
   output logic [AW-1:0]  lim_lo,
   output logic [AW-1:0]  lim_hi
);
   localparam logic [SRW-1:0] SEL_TAB [LIM_N] = '{LO_SEL, HI_SEL};

   logic [AW-1:0] lim_q [LIM_N];

   for (genvar g = 0; g < LIM_N; g++) begin : g_lim
      // The low limit opens at zero and the high limit at all ones
      localparam logic [AW-1:0] RST_VAL = (g == LIM_LO) ? '0 : '1;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lim_q[g] <= RST_VAL;
         else if (wr_en && wr_sel == SEL_TAB[g])
            lim_q[g] <= wr_data;
      end
   end

   assign lim_lo = lim_q[LIM_LO];
   assign lim_hi = lim_q[LIM_HI];

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < LIM_N; i++)
         if (rd_sel == SEL_TAB[i]) rd_data = lim_q[i];
   end

   // R1
   lim_reset_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (lim_lo == '0 && lim_hi == '1));
   // R2
   lim_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == LO_SEL) |=> lim_lo == $past(wr_data));
   // R2
   lim_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == HI_SEL) |=> lim_hi == $past(wr_data));
   // R2
   lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == LO_SEL || wr_sel == HI_SEL)) |=> ($stable(lim_lo) && $stable(lim_hi)));
endmodule

// File: rtl/stack_window_guard_select.sv
`timescale 1ns/1ps
module stack_window_guard_select
   import stack_window_guard_pkg::*;
#(
   parameter int unsigned RIW    = 5,
   parameter int unsigned SP_REG = 1
) (
   input  logic           vld,
   input  logic [RIW-1:0] base,
   input  logic [RIW-1:0] idx,
   input  logic           rr_form,
   output logic           sp_hit
);
   localparam logic [RIW-1:0] SP = RIW'(SP_REG);

   logic base_sp;
   logic idx_sp;

   assign base_sp = (base == SP);
   // The index operand only exists in the register-plus-register form
   assign idx_sp  = (addr_form_e'(rr_form) == FORM_REG_REG) && (idx == SP);
   assign sp_hit  = vld && (base_sp || idx_sp);
endmodule

// File: rtl/stack_window_guard_cmp.sv
`timescale 1ns/1ps
module stack_window_guard_cmp #(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic          outside
);
   logic below;
   logic above;

   // Unsigned compares; the bounds themselves are inside the window
   assign below   = addr < lo;
   assign above   = addr > hi;
   assign outside = below | above;
endmodule

// File: rtl/stack_window_guard.sv
`timescale 1ns/1ps
module stack_window_guard #(
   parameter int unsigned          AW         = 32,
   parameter int unsigned          RIW        = 5,
   parameter int unsigned          SRW        = 14,
   parameter int unsigned          CW         = 5,
   parameter int unsigned          SP_REG     = 1,
   parameter int unsigned          CAUSE_CODE = 7,
   parameter logic [SRW-1:0]       LO_SEL     = 'h800,
   parameter logic [SRW-1:0]       HI_SEL     = 'h802
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           acc_vld,
   input  logic [AW-1:0]  acc_addr,
   input  logic [RIW-1:0] acc_base,
   input  logic [RIW-1:0] acc_idx,
   input  logic           acc_rr,
   input  logic           sr_wr_en,
   input  logic [SRW-1:0] sr_wr_sel,
   input  logic [AW-1:0]  sr_wr_data,
   input  logic [SRW-1:0] sr_rd_sel,
   output logic [AW-1:0]  sr_rd_data,
   output logic           exc_req,
   output logic [CW-1:0]  exc_cause,
   output logic [AW-1:0]  exc_addr
);
   localparam logic [CW-1:0] CAUSE = CW'(CAUSE_CODE);

   // Elaboration-time parameter checks
   if (AW < 8) begin : g_bad_aw
      $error("stack_window_guard: AW must be at least 8");
   end
   if (LO_SEL == HI_SEL) begin : g_bad_sel
      $error("stack_window_guard: limit selectors must differ");
   end
   if (CAUSE_CODE >= (1 << CW)) begin : g_bad_cause
      $error("stack_window_guard: CAUSE_CODE does not fit in CW bits");
   end
   if (SP_REG >= (1 << RIW)) begin : g_bad_sp
      $error("stack_window_guard: SP_REG does not fit in RIW bits");
   end

   logic [AW-1:0] lim_lo;
   logic [AW-1:0] lim_hi;
   logic          sp_hit;
   logic          outside;
   logic          fault;

   stack_window_guard_limits #(
      .AW(AW), .SRW(SRW), .LO_SEL(LO_SEL), .HI_SEL(HI_SEL)
   ) u_limits (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sr_wr_en),
      .wr_sel  (sr_wr_sel),
      .wr_data (sr_wr_data),
      .rd_sel  (sr_rd_sel),
      .rd_data (sr_rd_data),
      .lim_lo  (lim_lo),
      .lim_hi  (lim_hi)
   );

   stack_window_guard_select #(
      .RIW(RIW), .SP_REG(SP_REG)
   ) u_select (
      .vld     (acc_vld),
      .base    (acc_base),
      .idx     (acc_idx),
      .rr_form (acc_rr),
      .sp_hit  (sp_hit)
   );

   stack_window_guard_cmp #(
      .AW(AW)
   ) u_cmp (
      .addr    (acc_addr),
      .lo      (lim_lo),
      .hi      (lim_hi),
      .outside (outside)
   );

   assign fault = sp_hit && outside;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_req   <= 1'b0;
         exc_cause <= '0;
         exc_addr  <= '0;
      end else begin
         exc_req   <= fault;
         exc_cause <= fault ? CAUSE : '0;
         exc_addr  <= fault ? acc_addr : '0;
      end
   end

   // R7
   exc_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> $past(acc_vld));
   // R8
   exc_cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> exc_cause == CAUSE);
   // R8
   exc_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> exc_addr == $past(acc_addr));
   // R8
   exc_quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> (exc_cause == '0 && exc_addr == '0));
   // R6
   no_sp_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !sp_hit) |=> !exc_req);
   // R3
   in_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_addr >= lim_lo && acc_addr <= lim_hi) |=> !exc_req);
endmodule

// File: tb/stack_window_guard_bench.sv
`timescale 1ns/1ps
module stack_window_guard_bench;
   typedef struct {
      bit          req;
      logic [31:0] addr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [4:0]  acc_base = '0;
   logic [4:0]  acc_idx = '0;
   logic        acc_rr = 1'b0;
   logic        sr_wr_en = 1'b0;
   logic [13:0] sr_wr_sel = '0;
   logic [31:0] sr_wr_data = '0;
   logic [13:0] sr_rd_sel = '0;
   logic [31:0] sr_rd_data;
   logic        exc_req;
   logic [4:0]  exc_cause;
   logic [31:0] exc_addr;

   int checks = 0;
   int fails  = 0;
   exp_t sb[$];
   logic [31:0] m_lo = 32'h0;
   logic [31:0] m_hi = 32'hFFFF_FFFF;

   always #5 clk = ~clk;

   stack_window_guard u_stack_window_guard (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
      .acc_base(acc_base), .acc_idx(acc_idx), .acc_rr(acc_rr),
      .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
      .sr_rd_sel(sr_rd_sel), .sr_rd_data(sr_rd_data),
      .exc_req(exc_req), .exc_cause(exc_cause), .exc_addr(exc_addr)
   );

   task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: one cycle of stimulus plus its expected outcome
   task automatic cyc(bit vld, logic [31:0] a, logic [4:0] b, logic [4:0] x, bit rr,
                      bit wen, logic [13:0] wsel, logic [31:0] wd, string tag);
      exp_t e;
      bit   used;
      @(negedge clk);
      acc_vld = vld; acc_addr = a; acc_base = b; acc_idx = x; acc_rr = rr;
      sr_wr_en = wen; sr_wr_sel = wsel; sr_wr_data = wd;
      used   = vld && (b == 5'd1 || (rr && x == 5'd1));
      e.req  = used && (a < m_lo || a > m_hi);
      e.addr = e.req ? a : 32'h0;
      e.tag  = tag;
      sb.push_back(e);
      if (wen && wsel == 14'h800) m_lo = wd;
      if (wen && wsel == 14'h802) m_hi = wd;
   endtask

   task automatic idle();
      cyc(1'b0, 32'h0, 5'd0, 5'd0, 1'b0, 1'b0, 14'h0, 32'h0, "idle R7");
   endtask

   task automatic acc(logic [31:0] a, logic [4:0] b, logic [4:0] x, bit rr, string tag);
      cyc(1'b1, a, b, x, rr, 1'b0, 14'h0, 32'h0, tag);
   endtask

   task automatic wr(logic [13:0] sel, logic [31:0] d);
      cyc(1'b0, 32'h0, 5'd0, 5'd0, 1'b0, 1'b1, sel, d, "write R2");
   endtask

   task automatic rd(logic [13:0] sel, logic [31:0] exp, string tag);
      idle();
      sr_rd_sel = sel;
      #1;
      check32(tag, sr_rd_data, exp);
   endtask

   // Monitor: compares registered exception outputs after each edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check32({e.tag, " req R7"}, {31'h0, exc_req}, {31'h0, e.req});
         check32({e.tag, " cause R8"}, {27'h0, exc_cause}, e.req ? 32'd7 : 32'd0);
         check32({e.tag, " addr R8"}, exc_addr, e.addr);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1;
      check32("reset exc_req R1", {31'h0, exc_req}, 32'h0);
      rd(14'h800, 32'h0, "reset low limit R1");
      rd(14'h802, 32'hFFFF_FFFF, "reset high limit R1");
      acc(32'h0, 5'd1, 5'd0, 1'b0, "open window low R1");
      acc(32'hFFFF_FFFF, 5'd1, 5'd0, 1'b0, "open window high R1");
      // R2: program and read back limits
      wr(14'h802, 32'h0000_1FFF);
      // R9: low limit written in the same cycle as a low access
      cyc(1'b1, 32'h0000_0800, 5'd1, 5'd0, 1'b0, 1'b1, 14'h800, 32'h0000_1000, "same-cycle old limit R9");
      acc(32'h0000_0800, 5'd1, 5'd0, 1'b0, "next-cycle new limit R9");
      rd(14'h800, 32'h0000_1000, "low limit readback R2");
      rd(14'h802, 32'h0000_1FFF, "high limit readback R2");
      wr(14'h801, 32'hDEAD_BEEF);
      rd(14'h801, 32'h0, "unmapped read R2");
      rd(14'h800, 32'h0000_1000, "unmapped write ignored low R2");
      rd(14'h802, 32'h0000_1FFF, "unmapped write ignored high R2");
      // R3: boundaries
      acc(32'h0000_1000, 5'd1, 5'd0, 1'b0, "equal low limit R3");
      acc(32'h0000_0FFF, 5'd1, 5'd0, 1'b0, "one below low R3");
      acc(32'h0000_1FFF, 5'd1, 5'd0, 1'b0, "equal high limit R3");
      acc(32'h0000_2000, 5'd1, 5'd0, 1'b0, "one above high R3");
      acc(32'hF000_0000, 5'd1, 5'd0, 1'b0, "unsigned large R3");
      idle();
      // R4 / R5: operand selection
      acc(32'h0000_0010, 5'd3, 5'd1, 1'b1, "index r1 reg-reg R4");
      acc(32'h0000_0010, 5'd1, 5'd3, 1'b1, "base r1 reg-reg R4");
      acc(32'h0000_0010, 5'd3, 5'd1, 1'b0, "index ignored reg-imm R5");
      // R6: no stack operand
      acc(32'h0000_0000, 5'd2, 5'd2, 1'b1, "no sp low R6");
      acc(32'hFFFF_FFFF, 5'd0, 5'd31, 1'b0, "no sp high R6");
      // R7: strobe qualification and back-to-back
      cyc(1'b0, 32'h0000_0004, 5'd1, 5'd1, 1'b1, 1'b0, 14'h0, 32'h0, "strobe low R7");
      acc(32'h0000_0004, 5'd1, 5'd0, 1'b0, "back-to-back first R7");
      acc(32'h0000_3000, 5'd1, 5'd0, 1'b0, "back-to-back second R7");
      idle();
      // R9: reopen high limit and retry
      cyc(1'b1, 32'h0000_3000, 5'd1, 5'd0, 1'b0, 1'b1, 14'h802, 32'hFFFF_FFFF, "high write same cycle R9");
      acc(32'h0000_3000, 5'd1, 5'd0, 1'b0, "high write next cycle R9");
      idle();
      idle();
      #5;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule